// File: doc/BRIEF.md
# External Analog Mux Channel Sequencer

This block drives a single-input converter that reads up to sixteen analog signals through an off-chip analog multiplexer. Software enables a set of logical channels, a settling delay, and the physical converter input that the multiplexer output is wired to. The sequencer then puts each enabled channel index on the multiplexer address pins, waits for the settling delay, and starts a conversion on the chosen physical input.

When the converter reports done, the result is stored under the logical channel that was on the address pins, never under the physical input. Each result register carries a valid bit that is cleared when the register is read.

The sequencer runs either a single pass, which ends with a sticky end-of-sequence flag, or continuous passes until it is told to stop. New configuration written while it runs is held and used from the next pass onward.

Top module: `amux_seq`

## Requirements
- R1: Enabled channels are converted in ascending index order within a pass, and disabled channels get no conversion.
- R2: `mux_addr[3:0]` carries the channel index, and `mux_addr[4]` is always 0.
- R3: A conversion result is written to the result register of the channel on `mux_addr`. The register of the physical mux input channel stays unwritten unless that channel is itself enabled.
- R4: `conv_phys` equals the mux-input selection field. Value 0 is the dedicated input pair, and value k+1 is auxiliary input k. The default is 0.
- R5: `conv_start` rises exactly S+1 cycles after the cycle in which `conv_done` was high, where S is the settle register.
- R6: `mux_addr` changes only after the done pulse of the conversion in progress.
- R7: A go with an all-zero enable mask leaves the block idle. It issues no `conv_start`, and `mux_addr` stays 0.
- R8: In single-pass mode, each enabled channel is converted once. Afterwards `busy` falls and `seq_end` is set; `seq_end` is cleared by the next go.
- R9: In continuous mode the pass wraps from the highest enabled channel back to the lowest. A stop request ends the run after the current conversion's done pulse, and `seq_end` stays 0.
- R10: A mask, settle or selection write made during a pass takes effect at the start of the next pass.
- R11: `rd_valid` for a channel is 1 after its result register is written, and it reads 0 after one read of that channel.
- R12: After reset, `busy`, `conv_start`, `seq_end` and `mux_addr` are 0, and no channel is valid.
- R13: Register map on `cfg_addr`:
  - 0: enable mask.
  - 1: settle cycles.
  - 2: mux-input selection.
  - 3: control. Bit 0 is go (accepted only when idle), bit 1 is stop, and bit 2 selects continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Held (shadow) configuration readback |
| rd_en | input | 1 | Result read strobe, clears the valid bit |
| rd_idx | input | 4 | Result channel to read |
| rd_data | output | 12 | Result of channel `rd_idx` |
| rd_valid | output | 1 | Valid bit of channel `rd_idx` |
| conv_start | output | 1 | One-cycle conversion start |
| conv_phys | output | 5 | Physical converter input to sample |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 12 | Converter result, valid with `conv_done` |
| mux_addr | output | 5 | External multiplexer address |
| busy | output | 1 | Sequence in progress |
| seq_end | output | 1 | Sticky end of single pass |

## Verification
The checker assumes the converter raises `conv_done` only while a conversion is outstanding, for one cycle per start. Address hold and result filing depend on a single done for each start. The bench's converter model waits for each start, holds a fixed latency, and returns exactly one done pulse. Configuration writes are issued only at negative clock edges, with the go bit sent while the block is idle.

// File: rtl/amux_pkg.sv
package amux_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_CONV} amux_state_e;
  localparam logic [1:0] REG_MASK   = 2'd0;
  localparam logic [1:0] REG_SETTLE = 2'd1;
  localparam logic [1:0] REG_SEL    = 2'd2;
  localparam logic [1:0] REG_CTRL   = 2'd3;
  localparam int CTRL_GO   = 0;
  localparam int CTRL_STOP = 1;
  localparam int CTRL_CONT = 2;
endpackage

// File: rtl/amux_pick.sv
module amux_pick #(
  parameter int N_CH = 16,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  mask,
  input  logic [IDX_W-1:0] cur,
  output logic             first_found,
  output logic [IDX_W-1:0] first_idx,
  output logic             next_found,
  output logic [IDX_W-1:0] next_idx
);
  // lowest set bit at or above 'from'; MSB of result flags a hit
  function automatic logic [IDX_W:0] scan_up(input logic [N_CH-1:0] m, input int from);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (i >= from && m[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  always_comb begin
    {first_found, first_idx} = scan_up(mask, 0);
    {next_found, next_idx}   = scan_up(mask, int'(cur) + 1);
  end
endmodule

// File: rtl/amux_cfg.sv
module amux_cfg
  import amux_pkg::*;
#(
  parameter int N_CH     = 16,
  parameter int SETTLE_W = 8,
  parameter int SEL_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          addr,
  input  logic [N_CH-1:0]     wdata,
  output logic [N_CH-1:0]     rdata,
  input  logic                load,
  output logic [N_CH-1:0]     sh_mask,
  output logic [SETTLE_W-1:0] sh_settle,
  output logic [N_CH-1:0]     act_mask,
  output logic [SETTLE_W-1:0] act_settle,
  output logic [SEL_W-1:0]    act_sel,
  output logic                act_cont,
  output logic                go_pulse,
  output logic                stop_pulse
);
  logic [SEL_W-1:0] sh_sel;
  logic             sh_cont;
  logic             ctrl_wr;

  assign ctrl_wr = we && addr == REG_CTRL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_mask <= '0; sh_settle <= '0; sh_sel <= '0; sh_cont <= 1'b0;
      go_pulse <= 1'b0; stop_pulse <= 1'b0;
    end else begin
      go_pulse   <= ctrl_wr && wdata[CTRL_GO];
      stop_pulse <= ctrl_wr && wdata[CTRL_STOP];
      if (we) begin
        case (addr)
          REG_MASK:   sh_mask   <= wdata;
          REG_SETTLE: sh_settle <= wdata[SETTLE_W-1:0];
          REG_SEL:    sh_sel    <= wdata[SEL_W-1:0];
          default:    sh_cont   <= wdata[CTRL_CONT];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mask <= '0; act_settle <= '0; act_sel <= '0; act_cont <= 1'b0;
    end else if (load) begin
      act_mask <= sh_mask; act_settle <= sh_settle;
      act_sel  <= sh_sel;  act_cont   <= sh_cont;
    end
  end

  always_comb begin
    case (addr)
      REG_MASK:   rdata = sh_mask;
      REG_SETTLE: rdata = N_CH'(sh_settle);
      REG_SEL:    rdata = N_CH'(sh_sel);
      default:    rdata = N_CH'({sh_cont, 2'b00});
    endcase
  end
endmodule

// File: rtl/amux_results.sv
module amux_results #(
  parameter int N_CH   = 16,
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] res_q [N_CH];
  logic [N_CH-1:0]   vld_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (we && widx == IDX_W'(g)) begin
        res_q[g] <= wdata;
        vld_q[g] <= 1'b1;   // write wins over a same-cycle read
      end else if (rd_en && rd_idx == IDX_W'(g)) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  assign rd_data  = res_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/amux_seq.sv
module amux_seq
  import amux_pkg::*;
#(
  parameter int N_CH     = 16,
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 8,
  parameter int MUX_W    = 5,
  localparam int IDX_W   = $clog2(N_CH),
  localparam int SEL_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [N_CH-1:0]   cfg_wdata,
  output logic [N_CH-1:0]   cfg_rdata,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              conv_start,
  output logic [SEL_W-1:0]  conv_phys,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [MUX_W-1:0]  mux_addr,
  output logic              busy,
  output logic              seq_end
);
  amux_state_e        state_q, state_d;
  logic [IDX_W-1:0]   cur_q, cur_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic               stop_q, seq_end_q, seq_end_d;

  logic [N_CH-1:0]     sh_mask, act_mask;
  logic [SETTLE_W-1:0] sh_settle, act_settle;
  logic [SEL_W-1:0]    act_sel;
  logic                act_cont, go_pulse, stop_pulse;
  logic                sh_first_found, act_first_found, act_next_found, sh_next_found;
  logic [IDX_W-1:0]    sh_first_idx, act_first_idx, act_next_idx, sh_next_idx;

  // named internal events for the checker
  logic go_ok, pass_load, res_we, slot_begin;

  amux_cfg #(.N_CH(N_CH), .SETTLE_W(SETTLE_W), .SEL_W(SEL_W)) u_cfg (
    .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .load(pass_load), .sh_mask, .sh_settle, .act_mask, .act_settle, .act_sel,
    .act_cont, .go_pulse, .stop_pulse);

  // shadow picker chooses the first channel of a new pass,
  // active picker chooses the next channel inside the running pass
  amux_pick #(.N_CH(N_CH)) u_pick_sh (
    .mask(sh_mask), .cur(cur_q), .first_found(sh_first_found), .first_idx(sh_first_idx),
    .next_found(sh_next_found), .next_idx(sh_next_idx));
  amux_pick #(.N_CH(N_CH)) u_pick_act (
    .mask(act_mask), .cur(cur_q), .first_found(act_first_found), .first_idx(act_first_idx),
    .next_found(act_next_found), .next_idx(act_next_idx));

  amux_results #(.N_CH(N_CH), .DATA_W(DATA_W)) u_res (
    .clk, .rst_n, .we(res_we), .widx(cur_q), .wdata(conv_data),
    .rd_en, .rd_idx, .rd_data, .rd_valid);

  assign go_ok  = go_pulse && state_q == ST_IDLE;
  assign res_we = state_q == ST_CONV && conv_done;

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    cnt_d     = cnt_q;
    seq_end_d = seq_end_q;
    pass_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go_ok) begin
        pass_load = 1'b1;
        seq_end_d = 1'b0;
        if (sh_first_found) begin
          state_d = ST_SETTLE; cur_d = sh_first_idx; cnt_d = sh_settle;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == '0) state_d = ST_CONV;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_CONV: if (conv_done) begin
        if (stop_q) begin
          state_d = ST_IDLE;
        end else if (act_next_found) begin
          state_d = ST_SETTLE; cur_d = act_next_idx; cnt_d = act_settle;
        end else if (act_cont) begin
          pass_load = 1'b1;
          if (sh_first_found) begin
            state_d = ST_SETTLE; cur_d = sh_first_idx; cnt_d = sh_settle;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          state_d   = ST_IDLE;
          seq_end_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign slot_begin = state_d == ST_SETTLE && state_q != ST_SETTLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cur_q <= '0; cnt_q <= '0;
      stop_q <= 1'b0; seq_end_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cur_q     <= cur_d;
      cnt_q     <= cnt_d;
      seq_end_q <= seq_end_d;
      if (state_d == ST_IDLE)               stop_q <= 1'b0;
      else if (stop_pulse && state_q != ST_IDLE) stop_q <= 1'b1;
    end
  end

  assign busy       = state_q != ST_IDLE;
  assign conv_start = state_q == ST_SETTLE && cnt_q == '0;
  assign conv_phys  = act_sel;
  assign mux_addr   = busy ? MUX_W'(cur_q) : '0;
  assign seq_end    = seq_end_q;

  // sibling picker outputs the top does not need in this direction
  logic unused_pick;
  assign unused_pick = ^{sh_next_found, sh_next_idx, act_first_found, act_first_idx};
endmodule

// File: rtl/amux_seq_chk.sv
module amux_seq_chk #(
  parameter int SETTLE_W = 8,
  parameter int MUX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                conv_start,
  input logic                conv_done,
  input logic [MUX_W-1:0]    mux_addr,
  input logic                seq_end,
  input logic                res_we,
  input logic                slot_begin,
  input logic [SETTLE_W-1:0] act_settle
);
  // cycles since a channel slot began, saturating
  logic [SETTLE_W:0] since_slot;
  always_ff @(posedge clk) begin
    if (!rst_n)                 since_slot <= '0;
    else if (slot_begin)        since_slot <= '0;
    else if (~&since_slot)      since_slot <= since_slot + 1'b1;
  end

  assert_addr_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_addr[MUX_W-1]);
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> $stable(mux_addr));
  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> since_slot == (SETTLE_W+1)'(act_settle));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!conv_start && mux_addr == '0));
  assert_file_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (conv_done && busy));
  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_end) |-> !busy);
  assert_single_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

bind amux_seq amux_seq_chk #(.SETTLE_W(SETTLE_W), .MUX_W(MUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .conv_start(conv_start), .conv_done(conv_done),
  .mux_addr(mux_addr), .seq_end(seq_end), .res_we(res_we), .slot_begin(slot_begin),
  .act_settle(act_settle));

// File: tb/tb_amux_seq.sv
`timescale 1ns/1ps
module tb_amux_seq;
  localparam int LAT = 4;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [11:0] rd_data;
  logic        rd_valid, conv_start, conv_done = 1'b0, busy, seq_end;
  logic [4:0]  conv_phys, mux_addr;
  logic [11:0] conv_data = '0;

  amux_seq dut (.*);

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, errors = 0, cyc = 0;
  int n_log = 0, done_cyc = -1;
  int log_addr [64], log_phys [64], log_gap [64];
  logic [11:0] exp_res [16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: fixed latency, one done per start
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        int k;
        k = n_log;
        log_addr[k] = int'(mux_addr);
        log_phys[k] = int'(conv_phys);
        log_gap[k]  = (done_cyc < 0) ? -1 : cyc - done_cyc;
        n_log++;
        repeat (LAT) @(negedge clk);
        chk(mux_addr == 5'(log_addr[k]), "R6 addr held", int'(mux_addr), log_addr[k]);
        conv_data = {mux_addr[3:0], 8'(k + 17)};
        exp_res[mux_addr[3:0]] = conv_data;
        conv_done = 1'b1;
        done_cyc = cyc;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output bit v, output logic [11:0] d);
    @(negedge clk); rd_idx = 4'(idx); rd_en = 1'b1;
    #1; v = rd_valid; d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic start_run(input logic [15:0] ctrl);
    n_log = 0; done_cyc = -1;
    wr(2'd3, ctrl);
  endtask

  task automatic t_reset();
    bit v; logic [11:0] d;
    chk(!busy && !conv_start && !seq_end, "R12 flags", int'({busy, conv_start, seq_end}), 0);
    chk(mux_addr == 0, "R12 addr", int'(mux_addr), 0);
    chk(cfg_rdata == 16'h0, "R13 mask default", int'(cfg_rdata), 0);
    for (int i = 0; i < 16; i++) begin
      rd(i, v, d);
      chk(!v, "R12 valid clear", int'(v), 0);
    end
  endtask

  task automatic t_single();
    int exp_seq [4] = '{2, 5, 13, 15};
    bit v; logic [11:0] d;
    wr(2'd0, 16'hA024); wr(2'd1, 16'd3); wr(2'd2, 16'd0);
    start_run(16'h0001);
    wait_idle();
    chk(n_log == 4, "R8 one per channel", n_log, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_addr[i] == exp_seq[i], "R1 ascending order", log_addr[i], exp_seq[i]);
      chk(log_addr[i] < 16, "R2 addr msb", log_addr[i], exp_seq[i]);
      chk(log_phys[i] == 0, "R4 dedicated pair", log_phys[i], 0);
      if (i > 0) chk(log_gap[i] == 4, "R5 settle gap", log_gap[i], 4);
    end
    chk(seq_end && !busy, "R8 end flag", int'({seq_end, busy}), 2);
    chk(mux_addr == 0, "R8 idle addr", int'(mux_addr), 0);
    rd(0, v, d);
    chk(!v, "R3 physical register untouched", int'(v), 0);
    for (int i = 0; i < 4; i++) begin
      rd(exp_seq[i], v, d);
      chk(v, "R11 valid set", int'(v), 1);
      chk(d == exp_res[exp_seq[i]], "R3 filed by address", int'(d), int'(exp_res[exp_seq[i]]));
    end
    rd(5, v, d);
    chk(!v, "R11 cleared by read", int'(v), 0);
  endtask

  task automatic t_auxsel();
    bit v; logic [11:0] d;
    wr(2'd0, 16'h0208); wr(2'd1, 16'd0); wr(2'd2, 16'd8);
    start_run(16'h0001);
    wait_idle();
    chk(n_log == 2, "R1 skip disabled", n_log, 2);
    chk(log_addr[0] == 3 && log_addr[1] == 9, "R1 order", log_addr[1], 9);
    chk(log_phys[0] == 8 && log_phys[1] == 8, "R4 aux input", log_phys[1], 8);
    chk(log_gap[1] == 1, "R5 zero settle", log_gap[1], 1);
    rd(7, v, d);
    chk(!v, "R3 aux register untouched", int'(v), 0);
    rd(9, v, d);
    chk(v && d == exp_res[9], "R3 result in ch9", int'(d), int'(exp_res[9]));
  endtask

  task automatic t_zero();
    wr(2'd0, 16'h0000);
    start_run(16'h0001);
    repeat (40) begin
      @(negedge clk);
      if (busy || mux_addr != 0) break;
    end
    chk(n_log == 0, "R7 no start", n_log, 0);
    chk(!busy && mux_addr == 0, "R7 idle addr zero", int'(mux_addr), 0);
    chk(!seq_end, "R8 flag cleared by go", int'(seq_end), 0);
  endtask

  task automatic t_cont();
    int exp_seq [4] = '{1, 14, 6, 6};
    wr(2'd0, 16'h4002); wr(2'd1, 16'd2); wr(2'd2, 16'd0);
    start_run(16'h0005);
    for (int i = 0; i < 500 && n_log < 1; i++) @(negedge clk);
    wr(2'd0, 16'h0040);   // takes effect at the next pass
    chk(cfg_rdata == 16'h0040, "R10 held mask readback", int'(cfg_rdata), 16'h0040);
    for (int i = 0; i < 500 && n_log < 4; i++) @(negedge clk);
    wr(2'd3, 16'h0002);
    wait_idle();
    chk(n_log == 4, "R9 stop after current", n_log, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_addr[i] == exp_seq[i], "R10 R9 wrap order", log_addr[i], exp_seq[i]);
      if (i > 0) chk(log_gap[i] == 3, "R5 gap continuous", log_gap[i], 3);
    end
    chk(!busy && !seq_end, "R9 stopped without end flag", int'({busy, seq_end}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_auxsel();
    t_zero();
    t_cont();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule